// File: doc/BRIEF.md
# Comparator Change-Detect Interrupt Logic

This block turns changes on the outputs of up to two analog comparators into interrupt flags. Each comparator output is asynchronous to the core clock. It passes through a two-stage synchronizer, and a sampling latch then refreshes it on every machine-cycle phase-1 strobe. A second latch, the snapshot, takes the sampled level whenever software reads or writes the comparator control register. When the two latches disagree, a mismatch exists and the comparator's flag is set.

The mismatch is a level condition, not an edge. While it persists, a software clear of the flag is overridden. Software ends the mismatch by accessing the control register, since every write also implies a read. The mismatch also ends when the comparator returns to its earlier level. The flag itself stays set until software writes 0 to it, and software may write 1 to force an interrupt. The interrupt request is gated by a per-comparator enable, a peripheral enable and a global enable. The flags set whatever the state of those enables.

Top module: `cmp_chg_irq`

## Requirements
- R1: After reset, all flags, the sampled comparator state and the interrupt request are 0.
- R2: The sampling latch (visible on `cmp_state_o`) updates only on a clock edge where `phase1_i` is 1. A raw input change applied between edges appears on `cmp_state_o` after the third rising edge, counting only edges where `phase1_i` is held 1.
- R3: When the sampled level differs from the snapshot, the comparator's flag is 1 after the next rising edge.
- R4: A pulse on `ctrl_rd_i` or `ctrl_wr_i` loads each snapshot with the current sampled level. This ends the mismatch, so a later flag clear takes effect.
- R5: When the comparator returns to its snapshot level, the mismatch ends. The flag stays 1 until software writes 0 to it.
- R6: While a mismatch persists, a flag write of 0 has no effect: the set wins and the flag reads 1 after the edge.
- R7: With `flag_wr_i` = 1, `flag_wdata_i` is written to the flags. Bit i belongs to comparator i. Writing 1 sets a flag with no mismatch present.
- R8: `irq_o` is 1 exactly when (flag AND `cmp_ie_i`) is 1 for at least one comparator, and both `periph_ie_i` and `global_ie_i` are 1.
- R9: Flags set from a mismatch even when an enable is 0.
- R10: Each comparator has its own latches and flag. A change on one comparator leaves the other's flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_raw_i | input | NUM_CMP | Asynchronous comparator outputs, bit i = comparator i |
| phase1_i | input | 1 | Machine-cycle phase-1 strobe, enables the sampling latch |
| ctrl_rd_i | input | 1 | Control-register read strobe |
| ctrl_wr_i | input | 1 | Control-register write strobe (implies a read) |
| flag_wr_i | input | 1 | Flag register write strobe |
| flag_wdata_i | input | NUM_CMP | Flag write data, bit i = comparator i |
| cmp_ie_i | input | NUM_CMP | Per-comparator interrupt enable |
| periph_ie_i | input | 1 | Peripheral interrupt enable |
| global_ie_i | input | 1 | Global interrupt enable |
| cmp_state_o | output | NUM_CMP | Sampled comparator levels (the value a register read returns) |
| flag_o | output | NUM_CMP | Comparator change flags |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a flag clear that collides with a live mismatch. Software writes 0 while the snapshot still disagrees with the sampled level, and the set has to win. The bench reaches it by changing a comparator input and waiting out the synchronizer and the sample stage. It then writes the flag to 0 with no control access, and the flag must still read 1. The next step is a control-register read, after which the same clear succeeds. A second hard case returns the input to its earlier level with no register access at all. Here the flag must survive the end of the mismatch. A third run holds the phase strobe low so that a raw change is kept out of the sampling latch.

// File: rtl/cmp_chg_pkg.sv
package cmp_chg_pkg;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef struct packed {
    logic samp;
    logic snap;
  } cmp_latch_t;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cmp_chg_slice.sv
module cmp_chg_slice
  import cmp_chg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  input  logic phase1_i,
  input  logic snap_en_i,
  input  logic flag_wr_i,
  input  logic flag_wdata_i,
  output logic samp_o,
  output logic snap_o,
  output logic flag_o
);
  cmp_latch_t lat_q;
  logic       flag_q;
  logic       mismatch;

  assign mismatch = lat_q.samp ^ lat_q.snap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
    end else begin
      if (phase1_i)  lat_q.samp <= level_i;
      if (snap_en_i) lat_q.snap <= lat_q.samp;
    end
  end

  // mismatch set dominates a software write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flag_q <= 1'b0;
    else if (mismatch)  flag_q <= 1'b1;
    else if (flag_wr_i) flag_q <= flag_wdata_i;
  end

  assign samp_o = lat_q.samp;
  assign snap_o = lat_q.snap;
  assign flag_o = flag_q;
endmodule

// File: rtl/cmp_irq_gate.sv
module cmp_irq_gate #(
  parameter int unsigned NUM_CMP = 2
) (
  input  logic [NUM_CMP-1:0] flag_i,
  input  logic [NUM_CMP-1:0] ie_i,
  input  logic               periph_ie_i,
  input  logic               global_ie_i,
  output logic               irq_o
);
  logic any_src;

  always_comb begin
    any_src = 1'b0;
    for (int i = 0; i < NUM_CMP; i++) any_src = any_src | (flag_i[i] & ie_i[i]);
  end

  assign irq_o = any_src & periph_ie_i & global_ie_i;
endmodule

// File: rtl/cmp_chg_irq.sv
module cmp_chg_irq
  import cmp_chg_pkg::*;
#(
  parameter int unsigned NUM_CMP = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CMP-1:0] cmp_raw_i,
  input  logic               phase1_i,
  input  logic               ctrl_rd_i,
  input  logic               ctrl_wr_i,
  input  logic               flag_wr_i,
  input  logic [NUM_CMP-1:0] flag_wdata_i,
  input  logic [NUM_CMP-1:0] cmp_ie_i,
  input  logic               periph_ie_i,
  input  logic               global_ie_i,
  output logic [NUM_CMP-1:0] cmp_state_o,
  output logic [NUM_CMP-1:0] flag_o,
  output logic               irq_o
);
  logic [NUM_CMP-1:0] level_sync;
  logic [NUM_CMP-1:0] samp_q;
  logic [NUM_CMP-1:0] snap_q;
  logic               snap_en;

  // a write begins with a read, so both refresh the snapshot
  assign snap_en = ctrl_rd_i | ctrl_wr_i;

  cmp_sync #(
    .WIDTH (NUM_CMP),
    .STAGES(SYNC_DEPTH)
  ) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cmp_raw_i),
    .q_o   (level_sync)
  );

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_slice
    cmp_chg_slice slice_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .level_i     (level_sync[g]),
      .phase1_i    (phase1_i),
      .snap_en_i   (snap_en),
      .flag_wr_i   (flag_wr_i),
      .flag_wdata_i(flag_wdata_i[g]),
      .samp_o      (samp_q[g]),
      .snap_o      (snap_q[g]),
      .flag_o      (flag_o[g])
    );
  end

  cmp_irq_gate #(.NUM_CMP(NUM_CMP)) gate_i (
    .flag_i     (flag_o),
    .ie_i       (cmp_ie_i),
    .periph_ie_i(periph_ie_i),
    .global_ie_i(global_ie_i),
    .irq_o      (irq_o)
  );

  assign cmp_state_o = samp_q;
endmodule

// File: rtl/cmp_chg_chk.sv
module cmp_chg_chk #(
  parameter int unsigned NUM_CMP = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               phase1_i,
  input logic               ctrl_rd_i,
  input logic               ctrl_wr_i,
  input logic               flag_wr_i,
  input logic               global_ie_i,
  input logic               periph_ie_i,
  input logic [NUM_CMP-1:0] samp_q,
  input logic [NUM_CMP-1:0] snap_q,
  input logic [NUM_CMP-1:0] flag_o,
  input logic               irq_o
);
  AST_SAMPLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase1_i |=> $stable(samp_q)); // R2
  AST_SNAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_rd_i || ctrl_wr_i) |=> $stable(snap_q)); // R4
  AST_ACCESS_ENDS_MISMATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_rd_i || ctrl_wr_i) && !phase1_i |=> (snap_q == samp_q)); // R4
  AST_IRQ_NEEDS_GLOBAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(global_ie_i && periph_ie_i) |-> !irq_o); // R8
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_o != '0)); // R8

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_chk
    AST_MISMATCH_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (samp_q[g] != snap_q[g]) |=> flag_o[g]); // R3
    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_o[g] && !flag_wr_i |=> flag_o[g]); // R5
  end
endmodule

bind cmp_chg_irq cmp_chg_chk #(.NUM_CMP(NUM_CMP)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .phase1_i   (phase1_i),
  .ctrl_rd_i  (ctrl_rd_i),
  .ctrl_wr_i  (ctrl_wr_i),
  .flag_wr_i  (flag_wr_i),
  .global_ie_i(global_ie_i),
  .periph_ie_i(periph_ie_i),
  .samp_q     (samp_q),
  .snap_q     (snap_q),
  .flag_o     (flag_o),
  .irq_o      (irq_o)
);

// File: tb/cmp_chg_irq_tb_top.sv
`timescale 1ns/1ps
module cmp_chg_irq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] raw = '0;
  logic       ph = 1'b1;
  logic       rd = 1'b0;
  logic       wr = 1'b0;
  logic       fwr = 1'b0;
  logic [1:0] fdata = '0;
  logic [1:0] ie = 2'b11;
  logic       pie = 1'b1;
  logic       gie = 1'b1;
  logic [1:0] state;
  logic [1:0] flag;
  logic       irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    string      req;
    logic [1:0] flag;
    logic       irq;
    logic [1:0] state;
  } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  cmp_chg_irq #(.NUM_CMP(2)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cmp_raw_i   (raw),
    .phase1_i    (ph),
    .ctrl_rd_i   (rd),
    .ctrl_wr_i   (wr),
    .flag_wr_i   (fwr),
    .flag_wdata_i(fdata),
    .cmp_ie_i    (ie),
    .periph_ie_i (pie),
    .global_ie_i (gie),
    .cmp_state_o (state),
    .flag_o      (flag),
    .irq_o       (irq)
  );

  // driver side: one clock edge, then push what must be seen after it
  task automatic tick(input string req, input logic [1:0] ef, input logic ei, input logic [1:0] es);
    exp_t e;
    @(posedge clk);
    e.req = req; e.flag = ef; e.irq = ei; e.state = es;
    sb_q.push_back(e);
    @(negedge clk);
  endtask

  // monitor: compare shortly after each edge
  always @(posedge clk) begin
    #1;
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_run++;
      if (flag !== e.flag || irq !== e.irq || state !== e.state) begin
        n_fail++;
        $display("FAIL %s: flag=%b irq=%b state=%b expected flag=%b irq=%b state=%b",
                 e.req, flag, irq, state, e.flag, e.irq, e.state);
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick("R1", 2'b00, 1'b0, 2'b00);

    // comparator 0 rises, phase strobe held
    raw = 2'b01;
    tick("R2", 2'b00, 1'b0, 2'b00);
    tick("R2", 2'b00, 1'b0, 2'b00);
    tick("R2", 2'b00, 1'b0, 2'b01);
    tick("R3", 2'b01, 1'b1, 2'b01);

    // clear during live mismatch is overridden
    fwr = 1'b1; fdata = 2'b00;
    tick("R6", 2'b01, 1'b1, 2'b01);
    fwr = 1'b0;
    tick("R6", 2'b01, 1'b1, 2'b01);

    // read ends mismatch, then clear sticks
    rd = 1'b1;
    tick("R4", 2'b01, 1'b1, 2'b01);
    rd = 1'b0; fwr = 1'b1; fdata = 2'b00;
    tick("R4", 2'b00, 1'b0, 2'b01);
    fwr = 1'b0;
    tick("R4", 2'b00, 1'b0, 2'b01);

    // fall then return without any register access
    raw = 2'b00;
    tick("R2", 2'b00, 1'b0, 2'b01);
    tick("R2", 2'b00, 1'b0, 2'b01);
    tick("R2", 2'b00, 1'b0, 2'b00);
    tick("R3", 2'b01, 1'b1, 2'b00);
    raw = 2'b01;
    tick("R5", 2'b01, 1'b1, 2'b00);
    tick("R5", 2'b01, 1'b1, 2'b00);
    tick("R5", 2'b01, 1'b1, 2'b01);
    tick("R5", 2'b01, 1'b1, 2'b01);
    fwr = 1'b1; fdata = 2'b00;
    tick("R5", 2'b00, 1'b0, 2'b01);
    fwr = 1'b0;

    // phase strobe low blocks sampling
    ph = 1'b0; raw = 2'b00;
    for (int i = 0; i < 5; i++) tick("R2", 2'b00, 1'b0, 2'b01);
    ph = 1'b1;
    tick("R2", 2'b00, 1'b0, 2'b00);
    tick("R3", 2'b01, 1'b1, 2'b00);
    wr = 1'b1;
    tick("R4", 2'b01, 1'b1, 2'b00);
    wr = 1'b0; fwr = 1'b1; fdata = 2'b00;
    tick("R4", 2'b00, 1'b0, 2'b00);
    fwr = 1'b0;

    // forced flag and enable gating
    fwr = 1'b1; fdata = 2'b10;
    tick("R7", 2'b10, 1'b1, 2'b00);
    fwr = 1'b0; gie = 1'b0;
    tick("R8", 2'b10, 1'b0, 2'b00);
    gie = 1'b1; pie = 1'b0;
    tick("R8", 2'b10, 1'b0, 2'b00);
    pie = 1'b1; ie = 2'b01;
    tick("R8", 2'b10, 1'b0, 2'b00);
    ie = 2'b11;
    tick("R8", 2'b10, 1'b1, 2'b00);
    fwr = 1'b1; fdata = 2'b00;
    tick("R7", 2'b00, 1'b0, 2'b00);
    fwr = 1'b0;

    // comparator 1 alone, global enable off
    gie = 1'b0; raw = 2'b10;
    tick("R10", 2'b00, 1'b0, 2'b00);
    tick("R10", 2'b00, 1'b0, 2'b00);
    tick("R10", 2'b00, 1'b0, 2'b10);
    tick("R9", 2'b10, 1'b0, 2'b10);
    tick("R10", 2'b10, 1'b0, 2'b10);
    gie = 1'b1;
    tick("R8", 2'b10, 1'b1, 2'b10);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule